// File: doc/BRIEF.md
# Serial EEPROM word reader

This block fetches a single 16-bit word from a three-wire serial EEPROM. A start strobe with a word address launches a complete read frame: a short clock pulse with the chip select low, a 10-bit read command shifted out most significant bit first, 16 data bits shifted in most significant bit first, and a closing clock pulse with the chip select low again. The serial clock runs far below the system clock; every half-period of it lasts a fixed number of system cycles.

The EEPROM may be private, or shared with a second controller. In shared mode the block first raises a request and polls a grant line once per system cycle for a bounded number of attempts. Once granted, it reads the word and then pulses a release line to hand the EEPROM back. If the grant never comes, it pulses release, skips the frame and ends with an error. Each operation ends with a one-cycle done pulse that carries the word, an error flag and a flag for words that look blank (all zeros or all ones).

Top module: `mw_eeprom_reader`

## Requirements
- R1: After reset, and while idle, the chip select, serial clock, serial data out, request and release outputs are low, and busy and done are low.
- R2: The command is the 10-bit value {0, 1, 1, 0, addr[5:0]}, the same as 0x180 ORed with the address. It is sent first bit first, one bit per rising serial clock edge with chip select high, and the data line is held steady while the serial clock is high.
- R3: Each high phase of the serial clock lasts exactly HALF_CYC system cycles.
- R4: Each frame holds exactly two serial clock pulses with chip select low: one before the command and one after the data. It holds exactly 26 rising edges with chip select high (10 command and 16 data).
- R5: On the last 16 rising edges with chip select high, the returned data is sampled at the end of each high phase and assembled most significant bit first into data_o.
- R6: done_o is high for exactly one cycle per accepted start. data_o, err_o and bad_o are valid in that cycle. busy_o is high from the cycle after the start until done_o rises, and is low in the done cycle.
- R7: A start strobe that arrives while busy_o is high is ignored. It does not change the address being read, and it produces no further frame and no further done pulse.
- R8: bad_o is high in the done cycle exactly when the word read is 0x0000 or 0xFFFF.
- R9: In shared mode the request rises in the cycle after the start. A grant seen on any poll attempt up to and including attempt POLL_LIMIT is accepted. No chip select activity occurs before the grant.
- R10: In shared mode, if no grant is seen in POLL_LIMIT attempts, the request stays high for exactly POLL_LIMIT cycles, release pulses for one cycle, no frame is issued, and done comes with err_o high.
- R11: After a shared-mode frame ends, release pulses once and the request drops with it. done_o follows the release pulse by one cycle.
- R12: In private mode the request and release outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken when not busy |
| share_i | input | 1 | Shared mode select, sampled with start |
| addr_i | input | ADDR_W | Word address, sampled with start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Grant timeout, valid with done |
| bad_o | output | 1 | Word is all zeros or all ones, valid with done |
| data_o | output | DATA_W | Word read, valid with done |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| arb_req_o | output | 1 | Access request to the other owner |
| arb_gnt_i | input | 1 | Access grant |
| arb_rel_o | output | 1 | One-cycle access release pulse |

## Verification
The arbitration timeout and the acceptance of a grant can land on the same poll attempt. The bench raises the grant so that the grant is first seen exactly on attempt POLL_LIMIT, and again one attempt later. The first case must give a full frame and a clean word; the second must give no chip select activity, a request that lasted exactly POLL_LIMIT cycles and an error. A second overlap, a start strobe during an active frame, is provoked in the middle of the command phase. It is judged by the command address captured by the EEPROM model and by the count of done pulses.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_PRE, PH_CMD, PH_GAP, PH_DATA, PH_TERM} phase_e;
  typedef enum logic [1:0] {AR_IDLE, AR_WAIT, AR_HOLD} arb_e;
  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } pins_t;
  // start bit followed by read opcode
  localparam logic [2:0] RD_OP = 3'b110;
endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
  parameter int unsigned HALF_CYC = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = en_i && (cnt_q == LAST);

  if (HALF_CYC > 1) begin : g_gap
    a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/mw_frame_seq.sv
module mw_frame_seq import mw_pkg::*; #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              do_i,
  output logic              active_o,
  output logic              fin_o,
  output logic [DATA_W-1:0] word_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o
);
  localparam int unsigned CMD_W = ADDR_W + 4;
  localparam int unsigned LONG  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int unsigned IDX_W = $clog2(LONG);

  phase_e             phase_q, phase_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               hi_q, hi_d;
  logic               fin_q, fin_d;
  logic               capture;
  logic [CMD_W-1:0]   cmd_q;
  logic [DATA_W-1:0]  word_q;
  pins_t              pins_q;

  function automatic pins_t pins_of(input phase_e ph, input logic [IDX_W-1:0] ix,
                                    input logic h, input logic [CMD_W-1:0] c);
    pins_t p;
    p = '0;
    case (ph)
      PH_PRE, PH_TERM: p.sk = h;
      PH_CMD: begin p.cs = 1'b1; p.sk = h; p.di = c[ix]; end
      PH_GAP:  p.cs = 1'b1;
      PH_DATA: begin p.cs = 1'b1; p.sk = h; end
      default: p = '0;
    endcase
    return p;
  endfunction

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    hi_d    = hi_q;
    fin_d   = 1'b0;
    capture = 1'b0;
    case (phase_q)
      PH_IDLE: if (go_i) begin phase_d = PH_PRE; hi_d = 1'b0; end
      PH_PRE: if (tick_i) begin
        if (!hi_q) hi_d = 1'b1;
        else begin phase_d = PH_CMD; hi_d = 1'b0; idx_d = IDX_W'(CMD_W - 1); end
      end
      PH_CMD: if (tick_i) begin
        if (!hi_q) hi_d = 1'b1;
        else if (idx_q == '0) begin phase_d = PH_GAP; hi_d = 1'b0; end
        else begin idx_d = idx_q - IDX_W'(1); hi_d = 1'b0; end
      end
      PH_GAP: if (tick_i) begin
        phase_d = PH_DATA; hi_d = 1'b0; idx_d = IDX_W'(DATA_W - 1);
      end
      PH_DATA: if (tick_i) begin
        if (!hi_q) hi_d = 1'b1;
        else begin
          capture = 1'b1;
          hi_d    = 1'b0;
          if (idx_q == '0) phase_d = PH_TERM;
          else             idx_d = idx_q - IDX_W'(1);
        end
      end
      PH_TERM: if (tick_i) begin
        if (!hi_q) hi_d = 1'b1;
        else begin phase_d = PH_IDLE; hi_d = 1'b0; fin_d = 1'b1; end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      hi_q    <= 1'b0;
      fin_q   <= 1'b0;
      cmd_q   <= '0;
      word_q  <= '0;
      pins_q  <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      hi_q    <= hi_d;
      fin_q   <= fin_d;
      pins_q  <= pins_of(phase_d, idx_d, hi_d, cmd_q);
      if (go_i && phase_q == PH_IDLE) cmd_q <= {1'b0, RD_OP, addr_i};
      if (capture) word_q <= {word_q[DATA_W-2:0], do_i};
    end
  end

  assign active_o = (phase_q != PH_IDLE);
  assign fin_o    = fin_q;
  assign word_o   = word_q;
  assign cs_o     = pins_q.cs;
  assign sk_o     = pins_q.sk;
  assign di_o     = pins_q.di;

  a_r2_di_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_q.sk && $past(pins_q.sk)) |-> $stable(pins_q.di));
  a_r4_cs_after_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pins_q.cs) |-> (!pins_q.sk && $past(pins_q.sk)));
  a_r6_fin_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |=> !fin_q);
endmodule

// File: rtl/mw_share_arb.sv
module mw_share_arb import mw_pkg::*; #(
  parameter int unsigned POLL_LIMIT = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic share_i,
  input  logic gnt_i,
  input  logic finish_i,
  output logic req_o,
  output logic rel_o,
  output logic go_o,
  output logic timeout_o
);
  localparam int unsigned PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [PW-1:0] LAST = PW'(POLL_LIMIT - 1);

  arb_e          state_q;
  logic [PW-1:0] cnt_q;
  logic          go_q, rel_q, to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= AR_IDLE;
      cnt_q   <= '0;
      go_q    <= 1'b0;
      rel_q   <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      go_q  <= 1'b0;
      rel_q <= 1'b0;
      to_q  <= 1'b0;
      case (state_q)
        AR_IDLE: if (start_i) begin
          if (share_i) begin state_q <= AR_WAIT; cnt_q <= '0; end
          else go_q <= 1'b1;
        end
        AR_WAIT: begin
          if (gnt_i) begin
            state_q <= AR_HOLD;
            go_q    <= 1'b1;
          end else if (cnt_q == LAST) begin
            state_q <= AR_IDLE;
            rel_q   <= 1'b1;
            to_q    <= 1'b1;
          end else cnt_q <= cnt_q + PW'(1);
        end
        AR_HOLD: if (finish_i) begin
          state_q <= AR_IDLE;
          rel_q   <= 1'b1;
        end
        default: state_q <= AR_IDLE;
      endcase
    end
  end

  assign req_o     = (state_q != AR_IDLE);
  assign rel_o     = rel_q;
  assign go_o      = go_q;
  assign timeout_o = to_q;

  a_r10_rel_drops_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_q |-> !req_o);
  a_r9_go_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_q && state_q == AR_HOLD) |-> $past(gnt_i));
  a_r11_rel_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_q && !to_q) |-> $past(finish_i));
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader #(
  parameter int unsigned HALF_CYC   = 10,
  parameter int unsigned POLL_LIMIT = 4000,
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned DATA_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              share_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              bad_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  input  logic              ee_do_i,
  output logic              arb_req_o,
  input  logic              arb_gnt_i,
  output logic              arb_rel_o
);
  logic              busy_q, done_q, err_q, bad_q, share_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              start_acc, end_evt;
  logic              go, tick, seq_active, seq_fin, arb_to, word_bad;
  logic [DATA_W-1:0] seq_word;

  assign start_acc = start_i && !busy_q;
  assign end_evt   = (seq_fin && !share_q) || arb_rel_o;
  assign word_bad  = (seq_word == '0) || (seq_word == '1);

  mw_share_arb #(.POLL_LIMIT(POLL_LIMIT)) u_arb (
    .clk_i, .rst_ni,
    .start_i  (start_acc),
    .share_i  (share_i),
    .gnt_i    (arb_gnt_i),
    .finish_i (seq_fin),
    .req_o    (arb_req_o),
    .rel_o    (arb_rel_o),
    .go_o     (go),
    .timeout_o(arb_to)
  );

  mw_tick_gen #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk_i, .rst_ni,
    .en_i   (seq_active),
    .tick_o (tick)
  );

  mw_frame_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni,
    .go_i     (go),
    .tick_i   (tick),
    .addr_i   (addr_q),
    .do_i     (ee_do_i),
    .active_o (seq_active),
    .fin_o    (seq_fin),
    .word_o   (seq_word),
    .cs_o     (ee_cs_o),
    .sk_o     (ee_sk_o),
    .di_o     (ee_di_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      bad_q   <= 1'b0;
      share_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      done_q <= end_evt;
      if (start_acc) begin
        busy_q  <= 1'b1;
        share_q <= share_i;
        addr_q  <= addr_i;
      end else if (end_evt) begin
        busy_q <= 1'b0;
      end
      if (end_evt) begin
        err_q  <= arb_to;
        bad_q  <= !arb_to && word_bad;
        data_q <= arb_to ? '0 : seq_word;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign bad_o  = bad_q;
  assign data_o = data_q;

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r6_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
  a_r7_addr_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(addr_q));
  a_r9_frame_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ee_cs_o) |-> (!share_q || arb_req_o));
  a_r12_private_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !share_q) |-> (!arb_req_o && !arb_rel_o));
endmodule

// File: tb/mw_eeprom_reader_test.sv
module mw_eeprom_reader_test;
  localparam int HALF = 3;
  localparam int POLL = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, share = 1'b0, gnt = 1'b0;
  logic [5:0]  addr = '0;
  logic        busy, done, err, bad, ee_cs, ee_sk, ee_di, req, rel;
  logic        ee_do = 1'b0;
  logic [15:0] data;

  int checks = 0, errors = 0;
  int edge_cnt, low_pulses;
  logic [9:0]  cmd_rx;
  logic [15:0] mdl_word;

  always #10 clk = ~clk;

  mw_eeprom_reader #(.HALF_CYC(HALF), .POLL_LIMIT(POLL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .share_i(share), .addr_i(addr),
    .busy_o(busy), .done_o(done), .err_o(err), .bad_o(bad), .data_o(data),
    .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_di_o(ee_di), .ee_do_i(ee_do),
    .arb_req_o(req), .arb_gnt_i(gnt), .arb_rel_o(rel)
  );

  function automatic logic [15:0] mem(input int a);
    if (a == 5) return 16'h0000;
    if (a == 6) return 16'hFFFF;
    return 16'((a * 16'h1357) ^ 16'hA5C3);
  endfunction

  // EEPROM model
  always @(posedge ee_sk) begin
    if (ee_cs) begin
      edge_cnt = edge_cnt + 1;
      if (edge_cnt <= 10) cmd_rx = {cmd_rx[8:0], ee_di};
      if (edge_cnt == 10) mdl_word = mem(int'(cmd_rx[5:0]));
      if (edge_cnt >= 11 && edge_cnt <= 26) ee_do = mdl_word[26 - edge_cnt];
    end else low_pulses = low_pulses + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_read(input int a, input bit sh, input int gnt_at,
                          input bit intrude, input bit exp_err);
    int hi_run = 0, width_bad = 0, rel_cnt = 0, req_cyc = 0, cs_early = 0;
    int busy_bad = 0, i = 0;
    bit rel_prev = 0, rel_before = 0, got = 0, busy_at_done = 0;
    logic [15:0] w;
    edge_cnt = 0; low_pulses = 0; cmd_rx = '0;
    @(negedge clk);
    start = 1'b1; share = sh; addr = 6'(a);
    while (!got && i < 3000) begin
      @(negedge clk);
      i++;
      if (i == 1) start = 1'b0;
      if (intrude && i == 30) begin start = 1'b1; addr = 6'(a + 10); end
      if (intrude && i == 31) start = 1'b0;
      if (ee_sk) hi_run++;
      else begin
        if (hi_run != 0 && hi_run != HALF) width_bad++;
        hi_run = 0;
      end
      if (rel) rel_cnt++;
      if (req) req_cyc++;
      if (sh && ee_cs && !gnt) cs_early++;
      if (done) begin got = 1; rel_before = rel_prev; busy_at_done = busy; end
      else if (!busy) busy_bad++;
      rel_prev = rel;
      if (gnt_at > 0 && i == gnt_at) gnt = 1'b1;
    end
    chk(got, "R6 done seen", int'(got), 1);
    chk(busy_bad == 0 && !busy_at_done, "R6 busy window", busy_bad, 0);
    w = mem(a);
    if (!exp_err) begin
      chk(data == w, "R5 data", int'(data), int'(w));
      chk(cmd_rx == {4'b0110, 6'(a)}, "R2 command", int'(cmd_rx), int'({4'b0110, 6'(a)}));
      chk(low_pulses == 2, "R4 low pulses", low_pulses, 2);
      chk(edge_cnt == 26, "R4 cs edges", edge_cnt, 26);
      chk(bad == (w == 16'h0 || w == 16'hFFFF), "R8 bad flag", int'(bad),
          int'(w == 16'h0 || w == 16'hFFFF));
      chk(err == 1'b0, "R6 err clear", int'(err), 0);
      chk(width_bad == 0, "R3 half period", width_bad, 0);
    end else begin
      chk(err == 1'b1, "R10 err", int'(err), 1);
      chk(edge_cnt == 0 && low_pulses == 0, "R10 no frame", edge_cnt + low_pulses, 0);
      chk(req_cyc == POLL, "R10 req cycles", req_cyc, POLL);
      chk(rel_cnt == 1 && rel_before, "R10 release", rel_cnt, 1);
    end
    if (sh && !exp_err) begin
      chk(rel_cnt == 1 && rel_before, "R11 release", rel_cnt, 1);
      chk(cs_early == 0, "R9 no early frame", cs_early, 0);
      chk(!req, "R11 req dropped", int'(req), 0);
    end
    if (!sh) chk(rel_cnt == 0 && req_cyc == 0, "R12 quiet arb", rel_cnt + req_cyc, 0);
    gnt = 1'b0;
    @(negedge clk);
    chk(!done && !busy, "R6 done single", int'(done), 0);
    if (intrude) begin
      int extra_done = 0, extra_cs = 0;
      for (int k = 0; k < 150; k++) begin
        @(negedge clk);
        if (done) extra_done++;
        if (ee_cs || busy) extra_cs++;
      end
      chk(extra_done == 0 && extra_cs == 0, "R7 strobe ignored", extra_done + extra_cs, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all): actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ee_cs && !ee_sk && !ee_di && !busy && !done && !req && !rel,
        "R1 reset state", int'({ee_cs, ee_sk, ee_di, busy, done, req, rel}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ee_cs && !ee_sk && !busy && !req, "R1 idle state",
        int'({ee_cs, ee_sk, busy, req}), 0);
    for (int a = 0; a < 64; a++) run_read(a, 1'b0, 0, 1'b0, 1'b0);
    run_read(12, 1'b0, 0, 1'b1, 1'b0);                 // R7
    run_read(33, 1'b1, 1, 1'b0, 1'b0);                 // R9 first attempt
    run_read(6, 1'b1, 7, 1'b0, 1'b0);                  // R9, R8
    run_read(47, 1'b1, POLL, 1'b0, 1'b0);              // R9 last attempt
    run_read(47, 1'b1, POLL + 1, 1'b0, 1'b1);          // R10 one attempt late
    run_read(21, 1'b1, 0, 1'b0, 1'b1);                 // R10 no grant
    run_read(5, 1'b0, 0, 1'b0, 1'b0);                  // R8 zero word
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule